// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is a two-wire bus slave that makes a synthesizable byte memory look like a serial EEPROM. It runs on a fast system clock. It resynchronizes the SCL and SDA lines and finds START and STOP conditions and clock edges. It decodes the device-select byte against two strap inputs, takes a two-byte word address, and then moves data in either direction. The block never drives SDA high. It only asserts an open-drain enable that pulls the line low.

Writes can be single bytes or pages of up to 64 bytes. During a page write the address stays inside its 64-byte page. A write-control input blocks all data writes. Reads can start at the address left by the previous access (current-address read), or at a new address loaded by a write-select address phase followed by a repeated START (random read). In either case the master keeps acknowledging to continue sequentially. The internal address counter is 15 bits wide. The storage behind it is `2**MEM_AW` bytes (1 KiB by default), indexed by the low address bits, so higher addresses alias onto it.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte is taken MSB first. It is acknowledged (SDA pulled low in the 9th clock) only when bits 7..4 = 1010, bit 3 = 0 and bits 2..1 equal strap_i[1:0]. Any other select byte is not acknowledged, and the slave ignores the bus until the next START.
- R2: The SDA drive enable changes only while SCL is low.
- R3: A write select (bit 0 = 0) is followed by a high address byte and then a low address byte, both acknowledged. High-byte bit 7 is ignored, giving a 15-bit address.
- R4: A random read is a write select plus two address bytes, a repeated START and a read select (bit 0 = 1). It returns the byte at the loaded address, MSB first.
- R5: A read select with no address phase returns data from the address counter. The counter keeps its value across transactions and points one past the last byte read or written.
- R6: Each byte read that the master acknowledges is followed by the next consecutive byte. The address rolls over from 0x7FFF to 0x0000.
- R7: During a write only the low 6 address bits advance after each stored byte, wrapping from 63 to 0 within the same page.
- R8: A write transaction stores at most 64 data bytes. The 65th data byte is not acknowledged and is not stored.
- R9: While wc_i is high, data bytes are neither acknowledged nor stored. Select and address bytes are still acknowledged and still load the address.
- R10: When the master does not acknowledge a read byte, the slave stops driving SDA and ignores clocks until a START or STOP.
- R11: After reset, and after any STOP, the slave is not driving SDA. A STOP before the low address byte leaves the address counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_i | input | 2 | Select-match straps, [1] to select bit 2, [0] to select bit 1 |
| wc_i | input | 1 | Write control, 1 blocks data writes |

## Verification
A corrupted bit counter or state would move the acknowledge slot by a clock, and the master would see a missing or extra ACK within the same byte. A wrong address counter shows up only at the next read, as a data mismatch on the first returned byte, which is why current-address reads follow writes and aborted transactions. Page-wrap and cap faults stay hidden until the page is read back, so those reads cover offset 0 of the page as well as the starting offset. Drive-timing faults appear on the line during SCL high, and a bench monitor catches them on the cycle they occur.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_SKIP
  } slv_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edge while clock held high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eeprom_ram.sv
module eeprom_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         MEM_AW   = 10,
  parameter int         PAGE_AW  = 6,
  parameter int         SYNC_LEN = 2,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_i,
  input  logic       wc_i
);
  localparam int HI_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  slv_st_e             st_q;
  logic [3:0]          bit_cnt_q;
  logic                ack_ph_q, sda_oe_q, rw_q, nack_q;
  logic [7:0]          shreg_q, tx_q;
  logic [HI_W-1:0]     hi_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PAGE_AW:0]    wr_cnt_q;
  logic [7:0]          rd_data;
  logic                sel_match, wr_ok, byte_ack, byte_done, mem_we;

  assign sel_match = (shreg_q[7:4] == DEV_TYPE) && !shreg_q[3] && (shreg_q[2:1] == strap_i);
  assign wr_ok     = !wc_i && !wr_cnt_q[PAGE_AW];
  assign byte_done = scl_fall && !ack_ph_q && (bit_cnt_q == 4'd8);

  always_comb begin
    case (st_q)
      ST_DEV:         byte_ack = sel_match;
      ST_AHI, ST_ALO: byte_ack = 1'b1;
      ST_WR:          byte_ack = wr_ok;
      default:        byte_ack = 1'b0;
    endcase
  end

  assign mem_we = (st_q == ST_WR) && byte_done && wr_ok;

  eeprom_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(addr_q[MEM_AW-1:0]),
    .wdata_i(shreg_q),
    .raddr_i(addr_q[MEM_AW-1:0]),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      hi_q      <= '0;
      addr_q    <= '0;
      wr_cnt_q  <= '0;
    end else if (start_det) begin
      st_q      <= ST_DEV;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (!ack_ph_q) begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              if (byte_ack) begin
                sda_oe_q <= 1'b1;
                ack_ph_q <= 1'b1;
              end else begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_SKIP;
              end
              case (st_q)
                ST_DEV: rw_q <= shreg_q[0];
                ST_AHI: hi_q <= shreg_q[HI_W-1:0];
                ST_ALO: addr_q <= {hi_q, shreg_q};
                default: begin
                  if (wr_ok) begin
                    // stay inside the current page
                    addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + PAGE_AW'(1);
                    wr_cnt_q <= wr_cnt_q + (PAGE_AW+1)'(1);
                  end
                end
              endcase
            end
          end else if (scl_fall) begin
            ack_ph_q  <= 1'b0;
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
            case (st_q)
              ST_DEV: begin
                if (rw_q) begin
                  st_q     <= ST_RD;
                  tx_q     <= rd_data;
                  sda_oe_q <= ~rd_data[7];
                end else begin
                  st_q <= ST_AHI;
                end
              end
              ST_AHI: st_q <= ST_ALO;
              ST_ALO: begin
                st_q     <= ST_WR;
                wr_cnt_q <= '0;
              end
              default: st_q <= ST_WR;
            endcase
          end
        end
        ST_RD: begin
          if (!ack_ph_q) begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                ack_ph_q <= 1'b1;
                addr_q   <= addr_q + ADDR_W'(1);
              end else begin
                tx_q     <= {tx_q[6:0], 1'b0};
                sda_oe_q <= ~tx_q[6];
              end
            end
          end else begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              ack_ph_q  <= 1'b0;
              bit_cnt_q <= '0;
              if (nack_q) begin
                st_q     <= ST_SKIP;
                sda_oe_q <= 1'b0;
              end else begin
                tx_q     <= rd_data;
                sda_oe_q <= ~rd_data[7];
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk #(
  parameter int ADDR_W  = 15,
  parameter int PAGE_AW = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              start_det,
  input logic              stop_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr_q
);
  localparam int CW = PAGE_AW + 2;
  localparam logic [CW-1:0] CAP = CW'(1) << PAGE_AW;
  logic [CW-1:0] wr_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      wr_seen <= '0;
    else if (start_det)               wr_seen <= '0;
    else if (mem_we && wr_seen != '1) wr_seen <= wr_seen + CW'(1);
  end

  a_r2_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  a_r11_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r7_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (addr_q[ADDR_W-1:PAGE_AW] == $past(addr_q[ADDR_W-1:PAGE_AW])));

  a_r8_page_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_seen <= CAP);
endmodule

bind i2c_eeprom_slave i2c_eeprom_chk #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .start_det(start_det),
  .stop_det (stop_det),
  .mem_we   (mem_we),
  .addr_q   (addr_q)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int Q      = 5;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe, oe_prev;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .wc_i(wc)
  );

  int n_chk = 0, n_err = 0, r2_viol = 0;
  logic [7:0]  mem_m [DEPTH];
  bit          known [DEPTH];
  logic [14:0] addr_m = '0;
  logic [7:0]  wbuf [80];

  always @(posedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) r2_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [14:0] wr_next(logic [14:0] a);
    return {a[14:6], a[5:0] + 6'd1};
  endfunction
  function automatic logic [14:0] rd_next(logic [14:0] a);
    return a + 15'd1;
  endfunction
  function automatic logic [7:0] sel_byte(bit rw);
    return {4'b1010, 1'b0, strap, rw};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input bit b, output bit s);
    sda_m = b; wq();
    scl = 1'b1; wq();
    s = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(!mack, s);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    bit ack;
    i2c_start();
    send_byte(sel_byte(1'b0), ack); chk(ack, "R1 write select ack", ack, 1);
    send_byte(a[15:8], ack);        chk(ack, "R3 high address ack", ack, 1);
    send_byte(a[7:0], ack);         chk(ack, "R3 low address ack", ack, 1);
    addr_m = a[14:0];
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    bit ack, exp;
    addr_phase(a);
    for (int k = 0; k < n; k++) begin
      exp = !wc && (k < 64);
      send_byte(wbuf[k], ack);
      chk(ack == exp, wc ? "R9 data ack under wc" : (k >= 64 ? "R8 page cap ack" : "R7 data ack"), ack, exp);
      if (exp) begin
        mem_m[addr_m[MEM_AW-1:0]] = wbuf[k];
        known[addr_m[MEM_AW-1:0]] = 1'b1;
        addr_m = wr_next(addr_m);
      end
    end
    i2c_stop();
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      if (known[addr_m[MEM_AW-1:0]])
        chk(d === mem_m[addr_m[MEM_AW-1:0]], req, d, mem_m[addr_m[MEM_AW-1:0]]);
      addr_m = rd_next(addr_m);
    end
    chk(sda_oe == 1'b0, "R10 release after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic do_rand_read(input logic [15:0] a, input int n, input string req);
    bit ack;
    addr_phase(a);
    i2c_start();
    send_byte(sel_byte(1'b1), ack); chk(ack, "R4 read select ack", ack, 1);
    read_bytes(n, req);
  endtask

  task automatic do_cur_read(input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(sel_byte(1'b1), ack); chk(ack, "R5 read select ack", ack, 1);
    read_bytes(n, req);
  endtask

  task automatic try_select(input logic [7:0] s, input bit exp);
    bit ack;
    i2c_start();
    send_byte(s, ack);
    chk(ack == exp, "R1 select decode", ack, exp);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 reset drive off", sda_oe, 0);

    // R1 select decode
    try_select(8'hB4, 1'b0);
    try_select(8'hAC, 1'b0);
    try_select(8'hA2, 1'b0);
    try_select(8'hA4, 1'b1);

    // R4 byte write and random read
    wbuf[0] = 8'h5A;
    do_write(16'h0123, 1);
    do_rand_read(16'h0123, 1, "R4 random read");

    // R5 / R6 current and sequential reads
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h30 + 8'(i);
    do_write(16'h0200, 4);
    do_rand_read(16'h0200, 1, "R4 random read");
    do_cur_read(2, "R5 current read");

    // R3 address bit 15 ignored
    wbuf[0] = 8'hC3;
    do_write(16'h8300, 1);
    do_rand_read(16'h0300, 1, "R3 bit15 ignored");

    // R7 page wrap
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h70 + 8'(i);
    do_write(16'h013C, 8);
    do_rand_read(16'h0100, 4, "R7 page wrap low");
    do_rand_read(16'h013C, 4, "R7 page wrap high");

    // R8 page cap
    for (int i = 0; i < 65; i++) wbuf[i] = 8'(i * 3 + 1);
    do_write(16'h0240, 65);
    do_rand_read(16'h0240, 1, "R8 65th byte not stored");

    // R9 write control
    wc = 1'b1;
    wbuf[0] = 8'hEE;
    do_write(16'h0300, 1);
    wc = 1'b0;
    do_rand_read(16'h0300, 1, "R9 memory unchanged");

    // R6 rollover
    wbuf[0] = 8'h11; do_write(16'h7FFF, 1);
    wbuf[0] = 8'h22; do_write(16'h0000, 1);
    do_rand_read(16'h7FFF, 2, "R6 rollover read");

    // R10 ignore after nack
    do_rand_read(16'h0200, 1, "R4 random read");
    for (int i = 0; i < 1; i++) begin
      i2c_start();
      send_byte(sel_byte(1'b1), ack);
      recv_byte(1'b0, d);
      addr_m = rd_next(addr_m);
      send_byte(8'h00, ack);
      chk(!ack, "R10 no drive after nack", ack, 0);
      i2c_stop();
    end

    // R11 stop before low address keeps counter
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h90 + 8'(i);
    do_write(16'h0400, 3);
    do_rand_read(16'h0400, 1, "R4 random read");
    i2c_start();
    send_byte(sel_byte(1'b0), ack);
    send_byte(8'h05, ack);
    i2c_stop();
    chk(sda_oe == 1'b0, "R11 stop drive off", sda_oe, 0);
    do_cur_read(1, "R11 counter kept");

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 8);
      case ($urandom % 3)
        0: begin
          for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
          do_write(a, n);
        end
        1: do_rand_read(a, n, "R6 sequential read");
        default: do_cur_read(n, "R5 current read");
      endcase
    end

    chk(r2_viol == 0, "R2 drive changes with SCL low", r2_viol, 0);
    report();
    $finish;
  end
endmodule